// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Victim Buffer

This block sits between a processor load/store port and one shared memory channel. It holds a direct-mapped set of multi-word lines. Each line carries a valid bit, a dirty bit and a tag. Read hits are answered one cycle after the request is taken. Stores that hit update the line in place and mark it dirty. A miss fetches the whole block from memory; a store miss then merges its word into the refilled block.

When a miss displaces a dirty line, the old block is copied into a one-entry victim buffer. The refill read goes out on the channel first. The processor is released as soon as the refill lands, and the buffered block is written out afterwards. While that write-out is running, requests that hit are still served at full rate. A miss must wait for a free channel, and the buffer must not be overwritten while it is full.

The processor holds a request until it sees `cpu_ready`. The memory side uses a simple request/acknowledge handshake with one transaction in flight at a time.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid, the victim buffer is empty, and `cpu_ready` and `mem_req` are low. The first access to any address is therefore a miss.
- R2: A word address splits as {tag, index, offset}, with the offset in the low bits. Word w of a block occupies bits [w*DATA_W +: DATA_W] of the block buses. `mem_addr` is the word address shifted right by the offset width. Reads return the most recently stored value of the addressed word.
- R3: A read hit raises `cpu_ready` with valid `cpu_rdata` in the cycle after the request is sampled, and issues no memory read.
- R4: A store hit updates only the addressed word and marks the line dirty. It causes no memory write at that time.
- R5: A miss issues exactly one block read of its own block. When a dirty line is displaced, that read goes out before the victim's block write, and the write carries the line's latest contents. A clean line is never written back, so the total number of memory writes equals the number of dirty evictions.
- R6: A miss completes with `cpu_ready` in the cycle after the refill acknowledge, before the buffered victim write has completed. A store miss leaves the refilled block with the stored word merged in and the other words taken from memory.
- R7: Hits issued while the victim buffer is draining are served with the same one-cycle latency.
- R8: A miss that arrives while a victim write owns the channel issues its read only after that write is acknowledged.
- R9: A miss that would displace a dirty line while the buffer is full stalls until the buffer empties. A miss to the block held in the buffer also waits for the write to finish, then reads the current data.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the start of a transaction until `mem_ack`. Only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W-log2(WORDS) | Block address |
| mem_wdata | output | DATA_W*WORDS | Block write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W*WORDS | Block read data, valid with `mem_ack` |

## Verification
The bench builds the cache with 8-bit word addresses, 16-bit words, two words per block and four lines. With that configuration, every one of the 256 words can be swept, and short address sequences force index conflicts, dirty evictions and buffer collisions. A scripted memory with a fixed three-cycle response gives each victim drain a window in which hits, blocked misses and misses to the buffered block can be placed deliberately. A bench-side tag/dirty model predicts hits, refill addresses and the total write-back count, and a reference word array checks every load.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic {ST_LOOKUP, ST_FILL} wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        dirty_q[wr_idx] <= wr_dirty;
      end
      if (mark_en) dirty_q[mark_idx] <= 1'b1;
    end
  end

  // Tag array without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R4: a line can only be marked dirty while it is valid
  a_r4_mark_valid: assert property (@(posedge clk) disable iff (rst)
    mark_en |-> valid_q[mark_idx]);
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int LINES = 16,
  parameter int BLK_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [BLK_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [BLK_W-1:0] rdata
);
  logic [BLK_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wdata;
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/wbc_victim_buf.sv
module wbc_victim_buf #(
  parameter int BADDR_W = 10,
  parameter int BLK_W   = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [BADDR_W-1:0] load_addr,
  input  logic [BLK_W-1:0]   load_data,
  input  logic               drained,
  output logic               full,
  output logic [BADDR_W-1:0] addr,
  output logic [BLK_W-1:0]   data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
    end else if (drained) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr <= load_addr;
      data <= load_data;
    end
  end

  // R9: the single entry is never overwritten while still occupied
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> !full);
  // R5: a drain completion only ever retires an occupied entry
  a_r5_drain_full: assert property (@(posedge clk) disable iff (rst)
    drained |-> full);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 16,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int BADDR_W = ADDR_W - OFF_W,
  localparam int BLK_W   = DATA_W * WORDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [BADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [BLK_W-1:0]   mem_rdata
);
  wbc_state_e state_q;

  logic [OFF_W-1:0]   req_off;
  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [BADDR_W-1:0] req_blk;

  assign req_off = cpu_addr[OFF_W-1:0];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_blk = cpu_addr[ADDR_W-1:OFF_W];

  // Miss context captured when the refill is launched
  logic               lat_we;
  logic [OFF_W-1:0]   lat_off;
  logic [IDX_W-1:0]   lat_idx;
  logic [TAG_W-1:0]   lat_tag;
  logic [DATA_W-1:0]  lat_wdata;

  logic               line_valid, line_dirty;
  logic [TAG_W-1:0]   line_tag;
  logic [BLK_W-1:0]   line_blk;
  logic               buf_full;
  logic [BADDR_W-1:0] buf_addr;
  logic [BLK_W-1:0]   buf_data;

  logic idle, hit, victim_dirty, buf_clash;
  logic take_hit, miss_go, drain_go, fill_done, drain_done;

  assign idle         = (state_q == ST_LOOKUP);
  assign hit          = line_valid && (line_tag == req_tag);
  assign victim_dirty = line_valid && line_dirty;
  assign buf_clash    = buf_full && (buf_addr == req_blk);
  assign take_hit     = idle && cpu_req && hit;
  assign miss_go      = idle && cpu_req && !hit && !mem_req && !buf_clash
                        && !(victim_dirty && buf_full);
  assign drain_go     = idle && buf_full && !mem_req && !miss_go;
  assign fill_done    = (state_q == ST_FILL) && mem_ack;
  assign drain_done   = idle && mem_req && mem_ack;

  // Word merge and selection for the hit path and the refill path
  logic [BLK_W-1:0]  hit_blk, fill_blk;
  logic [DATA_W-1:0] hit_word, fill_word;

  always_comb begin
    hit_blk  = line_blk;
    fill_blk = mem_rdata;
    for (int w = 0; w < WORDS; w++) begin
      if (OFF_W'(w) == req_off) hit_blk[w*DATA_W +: DATA_W] = cpu_wdata;
      if (lat_we && OFF_W'(w) == lat_off) fill_blk[w*DATA_W +: DATA_W] = lat_wdata;
    end
    hit_word  = line_blk[req_off*DATA_W +: DATA_W];
    fill_word = fill_blk[lat_off*DATA_W +: DATA_W];
  end

  wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .rd_valid (line_valid),
    .rd_dirty (line_dirty),
    .rd_tag   (line_tag),
    .wr_en    (fill_done),
    .wr_idx   (lat_idx),
    .wr_tag   (lat_tag),
    .wr_dirty (lat_we),
    .mark_en  (take_hit && cpu_we),
    .mark_idx (req_idx)
  );

  wbc_data_store #(.LINES(LINES), .BLK_W(BLK_W)) u_data (
    .clk   (clk),
    .we    (fill_done || (take_hit && cpu_we)),
    .widx  (fill_done ? lat_idx : req_idx),
    .wdata (fill_done ? fill_blk : hit_blk),
    .ridx  (req_idx),
    .rdata (line_blk)
  );

  wbc_victim_buf #(.BADDR_W(BADDR_W), .BLK_W(BLK_W)) u_vbuf (
    .clk       (clk),
    .rst       (rst),
    .load      (miss_go && victim_dirty),
    .load_addr ({line_tag, req_idx}),
    .load_data (line_blk),
    .drained   (drain_done),
    .full      (buf_full),
    .addr      (buf_addr),
    .data      (buf_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOOKUP;
    end else if (miss_go) begin
      state_q <= ST_FILL;
    end else if (fill_done) begin
      state_q <= ST_LOOKUP;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_go) begin
      lat_we    <= cpu_we;
      lat_off   <= req_off;
      lat_idx   <= req_idx;
      lat_tag   <= req_tag;
      lat_wdata <= cpu_wdata;
    end
  end

  // Channel arbiter: a refill read is launched ahead of any pending drain
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (miss_go) begin
      mem_req  <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= req_blk;
    end else if (drain_go) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b1;
      mem_addr  <= buf_addr;
      mem_wdata <= buf_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= take_hit || fill_done;
      if (take_hit)       cpu_rdata <= hit_word;
      else if (fill_done) cpu_rdata <= fill_word;
    end
  end

  // R5: a freshly buffered victim always finds the refill read already on the channel
  a_r5_fill_first: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> (mem_req && !mem_we));
  // R8: no victim write overlaps an outstanding refill
  a_r8_no_write_in_fill: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> !(mem_req && mem_we));
  // R10: request fields hold until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));
  // R6: the processor is released right after the refill lands
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_FILL) && mem_ack) |=> (cpu_ready && state_q == ST_LOOKUP));
endmodule

// File: tb/test_wbc_cache.sv
module test_wbc_cache;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int WD  = 2;
  localparam int LN  = 4;
  localparam int OW  = $clog2(WD);
  localparam int IW  = $clog2(LN);
  localparam int TW  = AW - IW - OW;
  localparam int BAW = AW - OW;
  localparam int BW  = DW * WD;
  localparam int LAT = 3;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [BAW-1:0] mem_addr;
  logic [BW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [BW-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wbc_cache #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD), .LINES(LN)) i_wbc_cache (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] phys [NW];
  logic [DW-1:0] refm [NW];
  int n_rd = 0, n_wr = 0, tx_n = 0;
  logic [BAW-1:0] last_rd;
  logic txw [16];
  logic [BAW-1:0] txa [16];

  // Cache model: valid, dirty, tag per line
  logic mv [LN];
  logic md [LN];
  logic [TW-1:0] mt [LN];
  int exp_writes = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory responder with fixed latency
  initial begin
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && !rst) begin
        wc++;
        if (wc >= LAT) begin
          wc = 0;
          for (int w = 0; w < WD; w++) begin
            if (mem_we) phys[int'(mem_addr)*WD + w] = mem_wdata[w*DW +: DW];
            else        mem_rdata[w*DW +: DW] = phys[int'(mem_addr)*WD + w];
          end
          if (mem_we) n_wr++;
          else begin n_rd++; last_rd = mem_addr; end
          txw[tx_n % 16] = mem_we;
          txa[tx_n % 16] = mem_addr;
          tx_n++;
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_tx(input int k, input logic we, input int a, input string req);
    chk(txw[k % 16] == we, req, "transaction kind", txw[k % 16], we);
    chk(int'(txa[k % 16]) == a, req, "transaction block", txa[k % 16], a);
  endtask

  // One processor access, checked against the model
  task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat, rd0;
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    bit exp_hit;
    idx = a[OW +: IW];
    tg  = a[AW-1 -: TW];
    exp_hit = mv[idx] && (mt[idx] == tg);
    if (!exp_hit && mv[idx] && md[idx]) exp_writes++;
    rd0 = n_rd;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready && lat < 400);
    cpu_req = 1'b0;
    if (exp_hit) begin
      chk(lat == 1, "R3", "hit latency", lat, 1);
      chk(n_rd == rd0, "R3", "reads during hit", n_rd, rd0);
    end else begin
      chk(lat > 1, "R5", "miss latency", lat, 2);
      chk(n_rd == rd0 + 1, "R5", "one refill read", n_rd, rd0 + 1);
      chk(last_rd == a[AW-1:OW], "R2", "refill block", last_rd, a[AW-1:OW]);
    end
    if (!we) chk(cpu_rdata == refm[a], exp_hit ? "R2" : "R6", "load data", cpu_rdata, refm[a]);
    else refm[a] = d;
    mv[idx] = 1'b1;
    mt[idx] = tg;
    md[idx] = exp_hit ? (md[idx] | we) : we;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, lat0;
    logic [31:0] seed;
    for (int i = 0; i < NW; i++) begin
      phys[i] = DW'(i * 59 + 17);
      refm[i] = phys[i];
    end
    for (int i = 0; i < LN; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(cpu_ready == 1'b0, "R1", "ready after reset", cpu_ready, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    // R1 / R2 / R3: cold miss, then a hit on the other word of the block
    lat0 = n_rd;
    op(0, 8'h00, '0);
    chk(n_rd == lat0 + 1, "R1", "first access misses", n_rd, lat0 + 1);
    op(0, 8'h01, '0);
    op(0, 8'h02, '0);

    // R4: store hit stays in the cache
    n0 = n_wr;
    op(1, 8'h01, 16'hA5C3);
    idle(20);
    chk(n_wr == n0, "R4", "no write on store hit", n_wr, n0);
    chk(phys[1] != 16'hA5C3, "R4", "memory untouched", phys[1], 0);
    op(0, 8'h01, '0);
    op(0, 8'h00, '0);

    // R5 / R6 / R7: dirty eviction, early release, hit during drain
    n0 = tx_n;
    op(0, 8'h08, '0);
    chk(tx_n == n0 + 1, "R6", "ready before victim write", tx_n, n0 + 1);
    op(0, 8'h02, '0);
    chk(mem_req && mem_we, "R7", "drain in flight during hit", mem_req && mem_we, 1);
    idle(20);
    chk_tx(n0, 0, 8'h04, "R5");
    chk_tx(n0 + 1, 1, 8'h00, "R5");
    chk(phys[1] == 16'hA5C3, "R5", "victim contents", phys[1], 16'hA5C3);

    // R8 / R6: miss waits for an in-flight drain; store-miss merge
    op(1, 8'h04, 16'h1234);
    idle(20);
    op(1, 8'h14, 16'h5678);
    idle(1);
    chk(mem_req && mem_we, "R8", "drain started", mem_req && mem_we, 1);
    n0 = tx_n;
    op(0, 8'h06, '0);
    chk_tx(n0, 1, 8'h02, "R8");
    chk_tx(n0 + 1, 0, 8'h03, "R8");
    op(0, 8'h14, '0);
    op(0, 8'h15, '0);
    idle(20);
    chk(phys[4] == 16'h1234, "R6", "merged store written back", phys[4], 16'h1234);

    // R9: miss to the buffered block waits for its drain
    op(1, 8'h02, 16'hBEEF);
    idle(20);
    n0 = tx_n;
    op(0, 8'h0A, '0);
    op(0, 8'h02, '0);
    chk_tx(n0, 0, 8'h05, "R9");
    chk_tx(n0 + 1, 1, 8'h01, "R9");
    chk_tx(n0 + 2, 0, 8'h01, "R9");

    // R9: second dirty eviction stalls while the buffer is full
    op(1, 8'h08, 16'h0F0F);
    op(1, 8'h06, 16'hF0F0);
    idle(20);
    n0 = tx_n;
    op(0, 8'h10, '0);
    op(0, 8'h16, '0);
    idle(20);
    chk_tx(n0, 0, 8'h08, "R9");
    chk_tx(n0 + 1, 1, 8'h04, "R9");
    chk_tx(n0 + 2, 0, 8'h0B, "R9");
    chk_tx(n0 + 3, 1, 8'h03, "R9");

    // Pseudo-random mixed traffic with varying gaps
    seed = 32'h1ACE_0B17;
    for (int i = 0; i < 800; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      op(seed[20], seed[31:24] & 8'h3F, seed[15:0]);
      idle(int'(seed[22:21]) % 3);
    end

    // Full sweep of every word
    for (int a = 0; a < NW; a++) op(0, AW'(a), '0);
    idle(30);
    chk(n_wr == exp_writes, "R5", "write-backs equal dirty evictions", n_wr, exp_writes);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule